// File: doc/BRIEF.md
# PWM Motor Voltage Regulator

This block drives the four gate enables of one H-bridge that spins a brushed DC motor. It holds the average voltage across the winding near a programmed target, so the motor speed stays steady as a battery supply sags. An external averaging network and comparator report each cycle whether one quarter of the averaged winding voltage lies below the level chosen by a 6-bit code (motor volts = 4 × 1.285 V × (code + 1) / 64). The block moves its duty value one step up or down once per PWM period in answer. The 6-bit code is handed on to the external converter only at a period boundary while the bridge runs.

Two direction bits pick coast, forward, reverse or brake. During the on part of each period the bridge drives the winding in the chosen direction. During the off part both high-side switches conduct so that the winding current circulates. When the target lies above the supply, the duty is pinned at full scale. After any start from coast, brake or a fault, a soft-start ceiling limits how fast the duty can climb. A current-sense comparator that stays tripped for a qualification time trims the duty down each period. A fault-disable input switches every gate off at once. One dead cycle separates opposite switches on the same leg.

Top module: `motor_pwm_regulator`

## Requirements
- R1: While reset is asserted, all four gate enables are 0, the duty output is 0 and the code output is 0.
- R2: Direction bits 00 (coast) switch off all four gates and hold the duty at 0, whatever the comparator and supply inputs do.
- R3: Direction bits 01 select forward (on time: left high-side and right low-side gates on). Direction bits 10 select reverse (on time: right high-side and left low-side gates on). A full-scale duty (all ones) keeps the on-time pattern steady.
- R4: During the off time both high-side gates are on and both low-side gates are off. A zero duty in forward or reverse gives this pattern at all times.
- R5: Direction bits 11 (brake) turn on both high-side gates, turn off both low-side gates, and hold the duty at 0.
- R6: The PWM period is 2^DUTY_W − 1 counts, and the duty changes only at the end of a period. With the below-target input at 1 the duty rises by one per period. With it at 0 the duty falls by one per period. The duty saturates at 0 and at full scale.
- R7: Entering forward or reverse from coast, brake or fault-disable restarts the duty at 0 under a ceiling that rises by one every RAMP_PERIODS periods. Switching straight between forward and reverse keeps the duty.
- R8: With the target-above-supply input at 1 and the ceiling at full scale, the duty jumps to full scale at the next period end, whatever the comparator says.
- R9: A current-sense trip that stays high for ILIM_QUAL_CLKS consecutive clocks lowers the duty by one at every period end while it stays high. This cut takes priority over R8. Shorter trip pulses change nothing.
- R10: On each leg the high-side and low-side gates are never on together, and a switch from one to the other passes through at least one clock with both off.
- R11: A fault-disable input at 1 turns all four gates off in the same cycle and clears the duty at the next clock edge.
- R12: The code output takes the 6-bit code at a period end while the bridge runs, and one clock later while it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vset_code | input | 6 | Target voltage code |
| bridge_ctl | input | 2 | Direction bits: 00 coast, 01 forward, 10 reverse, 11 brake |
| below_target | input | 1 | Comparator: averaged output / 4 below target |
| ilim_trip | input | 1 | Current-sense comparator above its threshold |
| target_over_supply | input | 1 | Target voltage above the supply |
| fault_disable | input | 1 | Forces all gates off and clears the duty |
| gate_hl | output | 1 | Left high-side gate enable |
| gate_ll | output | 1 | Left low-side gate enable |
| gate_hr | output | 1 | Right high-side gate enable |
| gate_lr | output | 1 | Right low-side gate enable |
| duty | output | DUTY_W | Present duty value |
| dac_code | output | 6 | Code handed to the reference converter |

## Verification
The comparator input is first held at 1 from a standstill. The spacing between duty steps then shows that the soft-start ceiling, not the tracker, sets the climb rate. It is then held at 0 from full scale, where the one-per-period spacing shows free tracking and saturation. A comparator that follows a threshold makes the duty dither between two adjacent values, which exercises every gate transition so the dead-time monitor sees both edges on both legs. Trip pulses just shorter than the qualification time are played against a held trip to separate the qualifier from the cut. The supply flag is set on its own to separate the forced full-scale jump from a ramp.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

   // Direction bits as seen on the control input
   typedef enum logic [1:0] {
      BR_COAST = 2'b00,
      BR_FWD   = 2'b01,
      BR_REV   = 2'b10,
      BR_BRAKE = 2'b11
   } bridge_mode_e;

   // Which switch of a half-bridge conducts
   typedef enum logic [1:0] {
      LEG_OFF  = 2'b00,
      LEG_HIGH = 2'b01,
      LEG_LOW  = 2'b10
   } leg_state_e;

   // Wanted state of one leg for a mode and PWM phase.
   // Off time and brake both recirculate through the high sides.
   function automatic leg_state_e leg_target(bridge_mode_e mode, logic pwm_on, logic is_left);
      case (mode)
         BR_FWD:   return (pwm_on && !is_left) ? LEG_LOW : LEG_HIGH;
         BR_REV:   return (pwm_on &&  is_left) ? LEG_LOW : LEG_HIGH;
         BR_BRAKE: return LEG_HIGH;
         default:  return LEG_OFF;
      endcase
   endfunction

endpackage

// File: rtl/mpr_period_timer.sv
module mpr_period_timer #(
   parameter int CNT_W   = 8,
   parameter int PWM_DIV = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] phase,
   output logic             period_end
);
   // Period is all-ones counts so that an all-ones duty is 100 %
   localparam logic [CNT_W-1:0] LAST_PHASE = {{(CNT_W-1){1'b1}}, 1'b0};

   logic             tick;
   logic [CNT_W-1:0] phase_q;

   generate
      if (PWM_DIV < 1) begin : g_bad_div
         $error("PWM_DIV must be at least 1");
      end
      if (PWM_DIV == 1) begin : g_no_div
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIVW = $clog2(PWM_DIV);
         logic [DIVW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)                      div_q <= '0;
            else if (div_q == DIVW'(PWM_DIV - 1))    div_q <= '0;
            else                                     div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIVW'(PWM_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run)  phase_q <= '0;
      else if (tick)       phase_q <= (phase_q == LAST_PHASE) ? '0 : phase_q + 1'b1;
   end

   assign phase      = phase_q;
   assign period_end = run && tick && (phase_q == LAST_PHASE);

endmodule

// File: rtl/mpr_ilim_qualifier.sv
module mpr_ilim_qualifier #(
   parameter int QUAL_CLKS = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   output logic qualified
);
   localparam int QW = $clog2(QUAL_CLKS + 1);

   logic [QW-1:0] run_q;

   generate
      if (QUAL_CLKS < 1) begin : g_bad_qual
         $error("QUAL_CLKS must be at least 1");
      end
   endgenerate

   // Consecutive-cycle counter, saturating at the qualification time
   always_ff @(posedge clk) begin
      if (!rst_n || !trip)               run_q <= '0;
      else if (run_q != QW'(QUAL_CLKS))  run_q <= run_q + 1'b1;
   end

   assign qualified = (run_q == QW'(QUAL_CLKS));

   // R9: a qualified trip implies the comparator was high on the last clock
   assert_qual_needs_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      qualified |-> $past(trip));

endmodule

// File: rtl/mpr_duty_tracker.sv
module mpr_duty_tracker #(
   parameter int DUTY_W       = 8,
   parameter int RAMP_PERIODS = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              period_end,
   input  logic              below_target,
   input  logic              over_supply,
   input  logic              cut_back,
   output logic [DUTY_W-1:0] duty
);
   localparam logic [DUTY_W-1:0] FULL_V = '1;
   localparam logic [DUTY_W-1:0] ZERO_V = '0;

   logic [DUTY_W-1:0] duty_q, ceil_q, ceil_nxt, raw, dec_v, inc_v;
   logic              ramp_wrap;

   generate
      if (RAMP_PERIODS < 1) begin : g_bad_ramp
         $error("RAMP_PERIODS must be at least 1");
      end
      if (RAMP_PERIODS == 1) begin : g_ramp_every
         assign ramp_wrap = 1'b1;
      end else begin : g_ramp_cnt
         localparam int RW = $clog2(RAMP_PERIODS);
         logic [RW-1:0] ramp_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !active) ramp_q <= '0;
            else if (period_end)   ramp_q <= (ramp_q == RW'(RAMP_PERIODS - 1)) ? '0 : ramp_q + 1'b1;
         end
         assign ramp_wrap = (ramp_q == RW'(RAMP_PERIODS - 1));
      end
   endgenerate

   always_comb begin
      dec_v    = (duty_q == ZERO_V) ? ZERO_V : duty_q - 1'b1;
      inc_v    = (duty_q == FULL_V) ? FULL_V : duty_q + 1'b1;
      ceil_nxt = (ramp_wrap && ceil_q != FULL_V) ? ceil_q + 1'b1 : ceil_q;
      if (cut_back)          raw = dec_v;
      else if (over_supply)  raw = FULL_V;
      else if (below_target) raw = inc_v;
      else                   raw = dec_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         duty_q <= ZERO_V;
         ceil_q <= ZERO_V;
      end else if (period_end) begin
         ceil_q <= ceil_nxt;
         duty_q <= (raw > ceil_nxt) ? ceil_nxt : raw;
      end
   end

   assign duty = duty_q;

   // R6: duty moves only on a period boundary or when the bridge stops
   assert_duty_moves_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q != $past(duty_q)) |-> ($past(period_end) || !$past(active)));

   // R6/R8: any rise needs the comparator or the supply flag
   assert_rise_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q > $past(duty_q)) |-> ($past(below_target) || $past(over_supply)));

   // R9: a qualified trip never lets the duty rise
   assert_cut_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cut_back) |-> (duty_q <= $past(duty_q)));

endmodule

// File: rtl/mpr_leg_driver.sv
module mpr_leg_driver
   import mpr_pkg::*;
#(
   parameter int DEAD_CLKS = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  leg_state_e want,
   input  logic       kill,
   output logic       hi_en,
   output logic       lo_en
);
   localparam int DW = $clog2(DEAD_CLKS + 1);

   leg_state_e    applied_q;
   logic [DW-1:0] dead_q;

   generate
      if (DEAD_CLKS < 1) begin : g_bad_dead
         $error("DEAD_CLKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         applied_q <= LEG_OFF;
         dead_q    <= '0;
      end else if (kill) begin
         applied_q <= LEG_OFF;
         dead_q    <= DW'(DEAD_CLKS - 1);
      end else if (want == applied_q) begin
         if (applied_q == LEG_OFF && dead_q != '0) dead_q <= dead_q - 1'b1;
      end else if (applied_q != LEG_OFF) begin
         applied_q <= LEG_OFF;
         dead_q    <= DW'(DEAD_CLKS - 1);
      end else if (dead_q != '0) begin
         dead_q <= dead_q - 1'b1;
      end else begin
         applied_q <= want;
      end
   end

   assign hi_en = (applied_q == LEG_HIGH) && !kill;
   assign lo_en = (applied_q == LEG_LOW)  && !kill;

   // R10: opposite switches of a leg are separated by a dead clock
   assert_dead_before_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_en) |-> !$past(hi_en));
   assert_dead_before_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_en) |-> !$past(lo_en));

endmodule

// File: rtl/motor_pwm_regulator.sv
module motor_pwm_regulator
   import mpr_pkg::*;
#(
   parameter int DUTY_W         = 8,
   parameter int CODE_W         = 6,
   parameter int PWM_DIV        = 1,
   parameter int RAMP_PERIODS   = 9,
   parameter int ILIM_QUAL_CLKS = 150,
   parameter int DEAD_CLKS      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] vset_code,
   input  logic [1:0]        bridge_ctl,
   input  logic              below_target,
   input  logic              ilim_trip,
   input  logic              target_over_supply,
   input  logic              fault_disable,
   output logic              gate_hl,
   output logic              gate_ll,
   output logic              gate_hr,
   output logic              gate_lr,
   output logic [DUTY_W-1:0] duty,
   output logic [CODE_W-1:0] dac_code
);
   localparam int N_LEGS = 2;

   generate
      if (DUTY_W < 2 || DUTY_W > 16) begin : g_bad_width
         $error("DUTY_W must lie in 2..16");
      end
      if (CODE_W < 1) begin : g_bad_code
         $error("CODE_W must be at least 1");
      end
   endgenerate

   bridge_mode_e      mode;
   logic              running;
   logic [DUTY_W-1:0] phase;
   logic              period_end;
   logic              ilim_qual;
   logic [DUTY_W-1:0] duty_w;
   logic              pwm_on;
   leg_state_e        want_v [N_LEGS];
   logic              hi_v   [N_LEGS];
   logic              lo_v   [N_LEGS];
   logic [CODE_W-1:0] code_q;

   assign mode    = bridge_mode_e'(bridge_ctl);
   assign running = (mode == BR_FWD || mode == BR_REV) && !fault_disable;

   mpr_period_timer #(
      .CNT_W   (DUTY_W),
      .PWM_DIV (PWM_DIV)
   ) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (running),
      .phase      (phase),
      .period_end (period_end)
   );

   mpr_ilim_qualifier #(
      .QUAL_CLKS (ILIM_QUAL_CLKS)
   ) ilim_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .trip      (ilim_trip),
      .qualified (ilim_qual)
   );

   mpr_duty_tracker #(
      .DUTY_W       (DUTY_W),
      .RAMP_PERIODS (RAMP_PERIODS)
   ) tracker_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (running),
      .period_end   (period_end),
      .below_target (below_target),
      .over_supply  (target_over_supply),
      .cut_back     (ilim_qual),
      .duty         (duty_w)
   );

   assign pwm_on = (phase < duty_w);

   generate
      for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
         assign want_v[g] = leg_target(mode, pwm_on, (g == 0));
         mpr_leg_driver #(
            .DEAD_CLKS (DEAD_CLKS)
         ) leg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want_v[g]),
            .kill  (fault_disable),
            .hi_en (hi_v[g]),
            .lo_en (lo_v[g])
         );
      end
   endgenerate

   // Code to the converter changes only on a period boundary while running
   always_ff @(posedge clk) begin
      if (!rst_n)                       code_q <= '0;
      else if (!running || period_end)  code_q <= vset_code;
   end

   assign gate_hl  = hi_v[0];
   assign gate_ll  = lo_v[0];
   assign gate_hr  = hi_v[1];
   assign gate_lr  = lo_v[1];
   assign duty     = duty_w;
   assign dac_code = code_q;

   // R11: disable forces every gate off at once
   assert_fault_gates_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_disable |-> !(gate_hl || gate_ll || gate_hr || gate_lr));
   // R11: duty cleared the clock after a disable
   assert_fault_clears_duty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fault_disable) |-> (duty == '0));
   // R2: coast on the previous clock leaves all gates off
   assert_coast_gates_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bridge_ctl) == 2'b00) |-> !(gate_hl || gate_ll || gate_hr || gate_lr));
   // R12: the converter code moves only at a boundary or while idle
   assert_code_at_boundary_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_code != $past(dac_code)) |-> ($past(period_end) || !$past(running)));

endmodule

// File: tb/motor_pwm_regulator_tb.sv
module motor_pwm_regulator_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW   = 5;
   localparam int FULL = 31;
   localparam int RAMP = 2;
   localparam int QUAL = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    vset_code = '0;
   logic [1:0]    bridge_ctl = 2'b00;
   logic          below_target = 1'b0;
   logic          ilim_trip = 1'b0;
   logic          target_over_supply = 1'b0;
   logic          fault_disable = 1'b0;
   logic          gate_hl, gate_ll, gate_hr, gate_lr;
   logic [DW-1:0] duty;
   logic [5:0]    dac_code;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  mon_on  = 1'b0;
   bit  p_hl, p_ll, p_hr, p_lr;

   always #(CLK_PERIOD/2) clk = ~clk;

   motor_pwm_regulator #(
      .DUTY_W (DW), .CODE_W (6), .PWM_DIV (1), .RAMP_PERIODS (RAMP),
      .ILIM_QUAL_CLKS (QUAL), .DEAD_CLKS (1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .vset_code (vset_code), .bridge_ctl (bridge_ctl),
      .below_target (below_target), .ilim_trip (ilim_trip),
      .target_over_supply (target_over_supply), .fault_disable (fault_disable),
      .gate_hl (gate_hl), .gate_ll (gate_ll), .gate_hr (gate_hr), .gate_lr (gate_lr),
      .duty (duty), .dac_code (dac_code)
   );

   function automatic int gates();
      return {28'd0, gate_hl, gate_ll, gate_hr, gate_lr};
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input string what, input int act, input int lo, input int hi);
      n_tests++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_change(output int n, input int limit);
      logic [DW-1:0] p;
      p = duty;
      n = 0;
      while (duty == p && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   // R10: continuous dead-time and shoot-through monitor
   always @(negedge clk) begin
      if (mon_on) begin
         if ((gate_hl && gate_ll) || (gate_hr && gate_lr) ||
             (gate_ll && p_hl) || (gate_hl && p_ll) ||
             (gate_lr && p_hr) || (gate_hr && p_lr)) begin
            n_fail++;
            $display("FAIL R10 dead time: actual gates %b prev %b expected a dead clock",
                     {gate_hl, gate_ll, gate_hr, gate_lr}, {p_hl, p_ll, p_hr, p_lr});
         end
      end
      p_hl = gate_hl; p_ll = gate_ll; p_hr = gate_hr; p_lr = gate_lr;
   end

   task automatic t_reset();
      vset_code = 6'd9; bridge_ctl = 2'b01; below_target = 1'b1;
      cyc(3);
      check("R1", "gates in reset", gates(), 0);
      check("R1", "duty in reset", duty, 0);
      check("R1", "code in reset", dac_code, 0);
      bridge_ctl = 2'b00; below_target = 1'b0;
      cyc(1);
      rst_n = 1'b1;
      mon_on = 1'b1;
   endtask

   task automatic t_coast();
      below_target = 1'b1; target_over_supply = 1'b1;
      cyc(2 * FULL);
      check("R2", "coast gates", gates(), 0);
      check("R2", "coast duty", duty, 0);
      target_over_supply = 1'b0;
   endtask

   task automatic t_soft_start();
      int n;
      int d0;
      below_target = 1'b1;
      bridge_ctl = 2'b01;
      cyc(1);
      check("R7", "duty at start", duty, 0);
      wait_change(n, 200);
      check("R7", "first ramp step value", duty, 1);
      for (int k = 0; k < 3; k++) begin
         d0 = duty;
         wait_change(n, 200);
         check("R7", "ramp spacing", n, RAMP * FULL);
         check("R7", "ramp step", duty, d0 + 1);
      end
      n = 0;
      while (duty != FULL && n < 2500) begin cyc(1); n++; end
      check("R6", "reached full scale", duty, FULL);
      cyc(3);
      for (int k = 0; k < 40; k++) begin
         if (gates() != 4'b1001) check("R3", "forward full-duty gates", gates(), 4'b1001);
         cyc(1);
      end
      check("R3", "forward full-duty gates", gates(), 4'b1001);
      cyc(2 * FULL);
      check("R6", "saturates at full", duty, FULL);
   endtask

   task automatic t_track_down();
      int n;
      int d0;
      below_target = 1'b0;
      wait_change(n, 200);
      check("R6", "first fall", duty, FULL - 1);
      for (int k = 0; k < 3; k++) begin
         d0 = duty;
         wait_change(n, 200);
         check("R6", "fall spacing", n, FULL);
         check("R6", "fall step", duty, d0 - 1);
      end
      cyc((FULL + 2) * FULL);
      check("R6", "saturates at zero", duty, 0);
      check("R4", "zero-duty recirculation gates", gates(), 4'b1010);
   endtask

   task automatic t_dither();
      int rises;
      bit prev_lr;
      rises = 0;
      prev_lr = gate_lr;
      for (int k = 0; k < 40 * FULL; k++) begin
         below_target = (duty < 12);
         cyc(1);
         if (gate_lr && !prev_lr) rises++;
         prev_lr = gate_lr;
      end
      check_rng("R6", "dither duty", duty, 11, 12);
      check_rng("R10", "low-side pulses seen", rises, 1, 100000);
   endtask

   task automatic t_direction();
      int hr_n, lr_n, ll_n;
      hr_n = 0; lr_n = 0; ll_n = 0;
      bridge_ctl = 2'b10;
      below_target = (duty < 12);
      cyc(1);
      check_rng("R7", "duty kept on direct reverse", duty, 11, 12);
      for (int k = 0; k < 3; k++) begin below_target = (duty < 12); cyc(1); end
      for (int k = 0; k < FULL; k++) begin
         below_target = (duty < 12);
         cyc(1);
         hr_n += gate_hr; lr_n += gate_lr; ll_n += gate_ll;
      end
      check("R3", "reverse right high always on", hr_n, FULL);
      check("R3", "reverse right low never on", lr_n, 0);
      check_rng("R3", "reverse left low pulses", ll_n, 8, 12);
   endtask

   task automatic t_over_supply();
      below_target = 1'b0;
      target_over_supply = 1'b1;
      cyc(FULL + 1);
      check("R8", "forced full duty", duty, FULL);
   endtask

   task automatic t_ilim();
      for (int k = 0; k < 14; k++) begin
         ilim_trip = 1'b1; cyc(QUAL - 1);
         ilim_trip = 1'b0; cyc(1);
         if (duty != FULL) check("R9", "short trips ignored", duty, FULL);
      end
      check("R9", "short trips ignored", duty, FULL);
      ilim_trip = 1'b1;
      cyc(3 * FULL);
      check_rng("R9", "held trip cuts duty", duty, FULL - 3, FULL - 2);
      ilim_trip = 1'b0;
      cyc(FULL + 1);
      check("R8", "full duty after trip clears", duty, FULL);
   endtask

   task automatic t_brake_restart();
      int n;
      int d0;
      bridge_ctl = 2'b11;
      cyc(3);
      check("R5", "brake gates", gates(), 4'b1010);
      check("R5", "brake duty", duty, 0);
      cyc(FULL);
      check("R5", "brake duty held", duty, 0);
      bridge_ctl = 2'b01;
      cyc(1);
      check("R7", "restart duty", duty, 0);
      wait_change(n, 200);
      check("R7", "restart first step", duty, 1);
      d0 = duty;
      wait_change(n, 200);
      check("R7", "restart ramp spacing under supply flag", n, RAMP * FULL);
      check("R7", "restart ramp step", duty, d0 + 1);
   endtask

   task automatic t_fault();
      @(negedge clk);
      fault_disable = 1'b1;
      #1;
      check("R11", "gates off at once", gates(), 0);
      cyc(1);
      check("R11", "duty cleared", duty, 0);
      cyc(3);
      check("R11", "gates stay off", gates(), 0);
      fault_disable = 1'b0;
      cyc(30);
      check("R7", "ramp restarts after disable", duty, 0);
      target_over_supply = 1'b0;
   endtask

   task automatic t_code();
      int n;
      bridge_ctl = 2'b00;
      vset_code = 6'd5;
      cyc(2);
      check("R12", "idle code follows", dac_code, 5);
      bridge_ctl = 2'b01;
      below_target = 1'b0;
      cyc(3);
      vset_code = 6'd40;
      n = 0;
      while (dac_code == 6'd5 && n < FULL + 2) begin cyc(1); n++; end
      check_rng("R12", "code waits for boundary", n, 1, FULL);
      check("R12", "code after boundary", dac_code, 40);
      vset_code = 6'd17;
      cyc(FULL - 1);
      check("R12", "code held within period", dac_code, 40);
      cyc(1);
      check("R12", "code at next boundary", dac_code, 17);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_coast();
      t_soft_start();
      t_track_down();
      t_dither();
      t_direction();
      t_over_supply();
      t_ilim();
      t_brake_restart();
      t_fault();
      t_code();
      n_tests++;   // R10 continuous monitor counted as one check
      finish_run();
   end

endmodule